// File: doc/BRIEF.md
# Button-Stepped LED Shifter

This block drives a row of LEDs in which a single lit position is walked one place at a time by two command strobes, one for each direction. Each strobe comes from a debounced push-button stage upstream and is high for exactly one clock cycle per complete press-and-release. Debouncing, clock division and pin mapping are done elsewhere.

After reset every LED is lit. The first accepted command does not rotate that pattern. It collapses it to a single lit LED at one end: bit 0 for a left command, the top bit for a right command. From then on each command rotates the lone lit bit by one place, and it wraps at both ends. The strobes are plain control pins with no handshake. A cycle with both strobes high is treated as a conflict and ignored. The LED pattern is visible on the output directly from a register, so no logic sits between the register and the pins.

Top module: `led_step_shifter`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted command, `leds` equals all ones (8'hFF with the default width).
- R2: The first left command after reset (`step_left`=1, `step_right`=0) leaves only bit 0 lit (8'h01).
- R3: The first right command after reset (`step_right`=1, `step_left`=0) leaves only the top bit lit (8'h80).
- R4: Once a single LED is lit, a left command moves it from bit i to bit i+1.
- R5: Once a single LED is lit, a right command moves it from bit i to bit i-1.
- R6: Stepping past an end wraps around. Left from the top bit goes to bit 0, and right from bit 0 goes to the top bit.
- R7: A cycle in which both strobes are high leaves `leds` unchanged. This includes the all-on state after reset, which then stays all-on.
- R8: `leds` changes only on a clock edge where exactly one strobe is high. It holds its value in every other cycle.
- R9: After the first accepted command, exactly one bit of `leds` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_left | input | 1 | One-cycle strobe: move the lit LED toward higher bit numbers |
| step_right | input | 1 | One-cycle strobe: move the lit LED toward lower bit numbers |
| leds | output | NUM_LEDS (8) | LED pattern, 1 means lit |

## Verification
Directed sequences start from reset with a right command and, separately, with a left command. These show whether the collapse from all-on picks the correct end instead of rotating. Full walks of more than eight steps in each direction pass both ends, so they separate wrapping from saturating or clearing. Conflicting strobes are applied both in the all-on state and in the single-lit state, and idle gaps are inserted between commands. Comparing the output before and after these cycles separates a real hold from a priority given to one direction.

// File: rtl/led_step_pkg.sv
package led_step_pkg;

  typedef enum logic [1:0] {
    STEP_NONE  = 2'd0,
    STEP_LEFT  = 2'd1,
    STEP_RIGHT = 2'd2
  } step_cmd_e;

endpackage

// File: rtl/led_step_cmd_decode.sv
module led_step_cmd_decode
  import led_step_pkg::*;
(
  input  logic      go_left,
  input  logic      go_right,
  output step_cmd_e cmd
);

  always_comb begin
    unique case ({go_left, go_right})
      2'b10:   cmd = STEP_LEFT;
      2'b01:   cmd = STEP_RIGHT;
      default: cmd = STEP_NONE;   // idle or conflicting strobes
    endcase
  end

  always_comb begin
    if (go_left && go_right)
      AST_CONFLICT_DROPPED: assert (cmd == STEP_NONE); // R7
  end

endmodule

// File: rtl/led_step_next.sv
module led_step_next
  import led_step_pkg::*;
#(
  parameter int NUM_LEDS = 8
) (
  input  logic [NUM_LEDS-1:0] cur,
  input  logic                spread,
  input  step_cmd_e           cmd,
  output logic [NUM_LEDS-1:0] nxt,
  output logic                load
);

  localparam int TOP = NUM_LEDS - 1;

  logic [NUM_LEDS-1:0] rot_up;
  logic [NUM_LEDS-1:0] rot_dn;
  logic [NUM_LEDS-1:0] end_lo;
  logic [NUM_LEDS-1:0] end_hi;

  assign rot_up = {cur[TOP-1:0], cur[TOP]};
  assign rot_dn = {cur[0], cur[TOP:1]};
  assign end_lo = {{(NUM_LEDS-1){1'b0}}, 1'b1};
  assign end_hi = {1'b1, {(NUM_LEDS-1){1'b0}}};

  assign load = (cmd != STEP_NONE);

  always_comb begin
    unique case (cmd)
      STEP_LEFT:  nxt = spread ? end_lo : rot_up;
      STEP_RIGHT: nxt = spread ? end_hi : rot_dn;
      default:    nxt = cur;
    endcase
  end

endmodule

// File: rtl/led_step_reg.sv
module led_step_reg #(
  parameter int NUM_LEDS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [NUM_LEDS-1:0] nxt,
  output logic [NUM_LEDS-1:0] pattern_q,
  output logic                spread_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pattern_q <= '1;
      spread_q  <= 1'b1;
    end else if (load) begin
      pattern_q <= nxt;
      spread_q  <= 1'b0;
    end
  end

  AST_SPREAD_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    spread_q |-> (&pattern_q)); // R1

  AST_SINGLE_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    !spread_q |-> ($countones(pattern_q) == 1)); // R9

endmodule

// File: rtl/led_step_shifter.sv
module led_step_shifter
  import led_step_pkg::*;
#(
  parameter int NUM_LEDS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_left,
  input  logic                step_right,
  output logic [NUM_LEDS-1:0] leds
);

  localparam int TOP = NUM_LEDS - 1;

  step_cmd_e           cmd;
  logic [NUM_LEDS-1:0] nxt;
  logic                load;
  logic                spread_q;

  led_step_cmd_decode u_decode (
    .go_left  (step_left),
    .go_right (step_right),
    .cmd      (cmd)
  );

  led_step_next #(.NUM_LEDS(NUM_LEDS)) u_next (
    .cur    (leds),
    .spread (spread_q),
    .cmd    (cmd),
    .nxt    (nxt),
    .load   (load)
  );

  led_step_reg #(.NUM_LEDS(NUM_LEDS)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .nxt       (nxt),
    .pattern_q (leds),
    .spread_q  (spread_q)
  );

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_left && !step_right) |=> $stable(leds)); // R8

  AST_BOTH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (step_left && step_right) |=> $stable(leds)); // R7

  AST_FIRST_LEFT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (step_left && !step_right && spread_q) |=> (leds == {{TOP{1'b0}}, 1'b1})); // R2

  AST_FIRST_RIGHT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (step_right && !step_left && spread_q) |=> (leds == {1'b1, {TOP{1'b0}}})); // R3

  AST_LEFT_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
    (step_left && !step_right && !spread_q) |=>
      (leds == {$past(leds[TOP-1:0]), $past(leds[TOP])})); // R4

  AST_RIGHT_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
    (step_right && !step_left && !spread_q) |=>
      (leds == {$past(leds[0]), $past(leds[TOP:1])})); // R5

endmodule

// File: tb/led_step_shifter_test.sv
`timescale 1ns/1ps
module led_step_shifter_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_left = 1'b0;
  logic       step_right = 1'b0;
  logic [7:0] leds;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  led_step_shifter #(.NUM_LEDS(8)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_left  (step_left),
    .step_right (step_right),
    .leds       (leds)
  );

  task automatic check(input logic [7:0] exp, input string req);
    n_checks++;
    if (leds !== exp) begin
      n_fails++;
      $display("FAIL %s: leds=%b expected=%b", req, leds, exp);
    end
  endtask

  // Drive strobes for one edge, then sample at the following falling edge.
  task automatic pulse(input logic l, input logic r);
    @(negedge clk);
    step_left  = l;
    step_right = r;
    @(negedge clk);
    step_left  = 1'b0;
    step_right = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(8'hFF, "R1 during reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(8'hFF, "R1 after release");
  endtask

  task automatic t_right_walk();
    logic [7:0] exp;
    do_reset();
    pulse(1'b0, 1'b1);
    check(8'h80, "R3 first right");
    pulse(1'b0, 1'b1);
    check(8'h40, "R5 second right");
    exp = 8'h40;
    for (int i = 0; i < 8; i++) begin
      pulse(1'b0, 1'b1);
      exp = {exp[0], exp[7:1]};
      check(exp, (exp == 8'h80) ? "R6 right wrap" : "R5 right step");
    end
  endtask

  task automatic t_left_walk();
    logic [7:0] exp;
    do_reset();
    pulse(1'b1, 1'b0);
    check(8'h01, "R2 first left");
    exp = 8'h01;
    for (int i = 0; i < 9; i++) begin
      pulse(1'b1, 1'b0);
      exp = {exp[6:0], exp[7]};
      check(exp, (exp == 8'h01) ? "R6 left wrap" : "R4 left step");
    end
  endtask

  task automatic t_conflict();
    do_reset();
    pulse(1'b1, 1'b1);
    check(8'hFF, "R7 both in all-on");
    pulse(1'b0, 1'b1);
    check(8'h80, "R3 right after conflict");
    pulse(1'b1, 1'b1);
    check(8'h80, "R7 both when single lit");
    pulse(1'b1, 1'b0);
    check(8'h01, "R6 left wrap from top");
  endtask

  task automatic t_idle_hold();
    do_reset();
    pulse(1'b1, 1'b0);
    pulse(1'b1, 1'b0);
    check(8'h02, "R4 two lefts");
    repeat (10) @(negedge clk);
    check(8'h02, "R8 idle hold");
    pulse(1'b0, 1'b1);
    check(8'h01, "R5 right from bit1");
    pulse(1'b0, 1'b1);
    check(8'h80, "R6 right wrap from bit0");
    repeat (5) @(negedge clk);
    check(8'h80, "R9 single lit held");
  endtask

  initial begin
    t_right_walk();
    t_left_walk();
    t_conflict();
    t_idle_hold();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule